// File: doc/BRIEF.md
# Peripheral Request to Channel Router

The router sits between a set of hardware peripheral request lines and the channels of a DMA controller. It keeps one small routing entry per peripheral requester. An entry holds either zero, which leaves that requester unconnected, or the number of a target channel plus one. Each clock, every incoming request pulse is steered to the channel its entry names. A per-channel software request pulse is merged into the same channel vector. Requester number 0 is kept for software-started transfers and has no entry, so hardware requesters are numbered from 1.

A request is latched as a pending flag on its channel. The flag stays up until the channel acknowledges it. It is cleared, and new requests are refused, while the channel is disabled. A channel served by a peripheral runs on the routed pulses alone. A channel used only by software needs a software request pulse while it is enabled.

The routing entries are written and read through a simple byte-addressed port. The entry for requester n sits at byte offset `TABLE_BASE + 4*(n-1)`, with `TABLE_BASE` = 0x2000 by default. Arbitration between channels and the data movement are handled elsewhere.

Top module: `rr_router`

## Requirements
- R1: While reset is asserted and after it, every routing entry reads zero and `ch_req` is all zero. Reset clears pending flags even when a request was pending before it.
- R2: A write at byte address `TABLE_BASE + 4*(n-1)`, for n from 1 to `NUM_REQ`, stores the low `ENT_W` bits of `cfg_wr_data` (3 bits by default) in the entry for requester n. A read at the same address returns that value zero-extended, from the cycle after the write.
- R3: Writes to addresses below the window, at or above `TABLE_BASE + 4*NUM_REQ`, or with address bits [1:0] not zero change no entry. Reads of such addresses return zero.
- R4: When the entry for requester n holds c+1, with c below `NUM_CH`, a pulse on `hw_req[n-1]` sets `ch_req[c]` at the next clock edge.
- R5: A pulse from a requester whose entry holds zero, or a value above `NUM_CH`, sets no channel request.
- R6: Requests from several requesters routed to the same channel are ORed into that one channel's request.
- R7: A pulse on `sw_req[c]` sets `ch_req[c]` at the next edge, ORed with any hardware request for that channel.
- R8: A set `ch_req[c]` stays high until a clock edge where `ch_ack[c]` is high, and is low after that edge. A new request in the same cycle as the acknowledge keeps it high.
- R9: While `ch_en[c]` is low, `ch_req[c]` is cleared at the next edge, and hardware or software requests for channel c are dropped.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock inside the block |
| cfg_wr_en | input | 1 | Routing entry write strobe |
| cfg_wr_addr | input | ADDR_W (16) | Byte address of the write |
| cfg_wr_data | input | DATA_W (32) | Write data; the low ENT_W bits are kept |
| cfg_rd_addr | input | ADDR_W (16) | Byte address of the read |
| cfg_rd_data | output | DATA_W (32) | Entry value at cfg_rd_addr, zero outside the window |
| hw_req | input | NUM_REQ (8) | Peripheral request pulses; bit n-1 is requester n |
| sw_req | input | NUM_CH (4) | Software request pulses, one per channel |
| ch_en | input | NUM_CH (4) | Channel enables |
| ch_ack | input | NUM_CH (4) | Channel acceptance of its pending request |
| ch_req | output | NUM_CH (4) | Pending request per channel |

## Verification
The properties assume that request, acknowledge and enable inputs change only between clock edges. They also assume these inputs stay quiet for the first cycle after reset is released, because the checker starts looking one cycle after the synchronized reset release. The stimulus drives every input just after the falling edge, keeps pulses one cycle wide, and holds all requests low across both resets. The read-back property assumes the read address is stable for the cycle it is compared. The bench holds each read address for exactly that cycle, and it reprograms an entry only in a cycle with no hardware request, so each check sees a single table state.

// File: rtl/rr_pkg.sv
package rr_pkg;

  // Byte distance between neighbouring routing entries is 1 << SLOT_LG2.
  localparam int unsigned SLOT_LG2 = 2;

  // Address lies inside the routing window and is entry aligned.
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned n_slots);
    logic [31:0] off;
    off = addr - base;
    return (addr >= base) && (off[SLOT_LG2-1:0] == '0) &&
           ((off >> SLOT_LG2) < n_slots);
  endfunction

  // Slot number (requester id minus one) addressed inside the window.
  function automatic int unsigned slot_of(input logic [31:0] addr,
                                          input logic [31:0] base);
    logic [31:0] off;
    off = (addr - base) >> SLOT_LG2;
    return int'(off);
  endfunction

endpackage

// File: rtl/rr_table.sv
module rr_table #(
  parameter int unsigned NUM_REQ    = 8,
  parameter int unsigned ENT_W      = 3,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter logic [31:0] TABLE_BASE = 32'h2000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [DATA_W-1:0]                rd_data,
  output logic [NUM_REQ-1:0][ENT_W-1:0]    entries
);
  import rr_pkg::*;

  localparam int unsigned IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0][ENT_W-1:0] ent_q, ent_d;
  logic                          wr_hit, rd_hit;
  logic [IDX_W-1:0]              wr_idx, rd_idx;
  logic                          unused_wr_hi;

  assign wr_hit = wr_en && in_window(32'(wr_addr), TABLE_BASE, NUM_REQ);
  assign rd_hit = in_window(32'(rd_addr), TABLE_BASE, NUM_REQ);
  assign wr_idx = IDX_W'(slot_of(32'(wr_addr), TABLE_BASE));
  assign rd_idx = IDX_W'(slot_of(32'(rd_addr), TABLE_BASE));
  assign unused_wr_hi = ^wr_data[DATA_W-1:ENT_W];

  always_comb begin
    ent_d = ent_q;
    if (wr_hit) ent_d[wr_idx] = wr_data[ENT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (wr_hit) ent_q <= ent_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = DATA_W'(ent_q[rd_idx]);
  end

  assign entries = ent_q;

endmodule

// File: rtl/rr_decode.sv
module rr_decode #(
  parameter int unsigned NUM_REQ = 8,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned ENT_W   = 3
) (
  input  logic [NUM_REQ-1:0][ENT_W-1:0] entries,
  input  logic [NUM_REQ-1:0]            hw_req,
  input  logic [NUM_CH-1:0]             sw_req,
  output logic [NUM_CH-1:0]             hit
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic h;
    always_comb begin
      h = sw_req[c];
      for (int r = 0; r < NUM_REQ; r++) begin
        if (hw_req[r] && (entries[r] == ENT_W'(c + 1))) h = 1'b1;
      end
    end
    assign hit[c] = h;
  end

endmodule

// File: rtl/rr_pending.sv
module rr_pending #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] en,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] pend
);

  logic [NUM_CH-1:0] pend_q, pend_d;
  logic              upd;

  // A fresh hit wins over an acknowledge in the same cycle.
  always_comb begin
    pend_d = ((pend_q & ~ack) | hit) & en;
    upd    = |(pend_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend = pend_q;

endmodule

// File: rtl/rr_router.sv
module rr_router #(
  parameter int unsigned NUM_REQ    = 8,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter logic [31:0] TABLE_BASE = 32'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic [ADDR_W-1:0] cfg_rd_addr,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic [NUM_REQ-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_req,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_ack,
  output logic [NUM_CH-1:0] ch_req
);

  localparam int unsigned ENT_W = $clog2(NUM_CH + 1);

  logic                          rst_meta_n, rst_q_n;
  logic [NUM_REQ-1:0][ENT_W-1:0] route_ent;
  logic [NUM_CH-1:0]             route_hit;

  // Assert at once, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  rr_table #(
    .NUM_REQ(NUM_REQ), .ENT_W(ENT_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .TABLE_BASE(TABLE_BASE)
  ) u_table (
    .clk(clk), .rst_n(rst_q_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
    .entries(route_ent)
  );

  rr_decode #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ENT_W(ENT_W)
  ) u_decode (
    .entries(route_ent), .hw_req(hw_req), .sw_req(sw_req), .hit(route_hit)
  );

  rr_pending #(
    .NUM_CH(NUM_CH)
  ) u_pend (
    .clk(clk), .rst_n(rst_q_n),
    .hit(route_hit), .en(ch_en), .ack(ch_ack), .pend(ch_req)
  );

endmodule

// File: rtl/rr_router_chk.sv
module rr_router_chk #(
  parameter int unsigned NUM_REQ    = 8,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ENT_W      = 3,
  parameter logic [31:0] TABLE_BASE = 32'h2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_CH-1:0] sw_req,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_ack,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] ch_req
);
  import rr_pkg::*;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R9: a channel disabled in the previous cycle shows no request.
  assert_drop_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (ch_req & ~$past(ch_en)) == '0);

  // R7: an enabled software pulse is pending on the next cycle.
  assert_sw_sets_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (ch_req & $past(sw_req & ch_en)) == $past(sw_req & ch_en));

  // R8: pending stays until acknowledged (or disabled).
  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(ch_req & ~ch_ack & ch_en) & ~ch_req) == '0);

  // R4: a request only rises on a decoded hit.
  assert_rise_from_hit_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (ch_req & ~$past(ch_req) & ~$past(hit)) == '0);

  // R2: an in-window write reads back on the next cycle.
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(wr_en) && (rd_addr == $past(wr_addr)) &&
     $past(in_window(32'(wr_addr), TABLE_BASE, NUM_REQ)))
    |-> (rd_data == DATA_W'($past(wr_data[ENT_W-1:0]))));

endmodule

bind rr_router rr_router_chk #(
  .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .ENT_W(ENT_W), .TABLE_BASE(TABLE_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_q_n),
  .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
  .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
  .sw_req(sw_req), .ch_en(ch_en), .ch_ack(ch_ack),
  .hit(route_hit), .ch_req(ch_req)
);

// File: tb/tb_rr_router.sv
`timescale 1ns/1ps
module tb_rr_router;

  localparam int NUM_REQ = 8;
  localparam int NUM_CH  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic [15:0] cfg_rd_addr;
  logic [31:0] cfg_rd_data;
  logic [NUM_REQ-1:0] hw_req;
  logic [NUM_CH-1:0]  sw_req, ch_en, ch_ack, ch_req;

  always #4 clk = ~clk;

  rr_router dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .hw_req(hw_req), .sw_req(sw_req), .ch_en(ch_en), .ch_ack(ch_ack),
    .ch_req(ch_req)
  );

  typedef struct {
    int          cyc;
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;

  // Monitor: one time step after each rising edge, compare due items.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        item_t it;
        logic [31:0] act;
        it  = sbq.pop_front();
        act = it.is_rd ? cfg_rd_data : 32'(ch_req);
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s: actual %h expected %h (cycle %0d)",
                   it.tag, it.is_rd ? "read" : "ch_req", act, it.exp, cyc);
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    cfg_wr_en = 1'b0;
    hw_req    = '0;
    sw_req    = '0;
    ch_ack    = '0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cfg_wr_en   = 1'b1;
    cfg_wr_addr = a;
    cfg_wr_data = d;
  endtask

  task automatic expect_req(input logic [NUM_CH-1:0] v, input string tag);
    item_t it;
    it = '{cyc + 1, 1'b0, 32'(v), tag};
    sbq.push_back(it);
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [31:0] v, input string tag);
    item_t it;
    cfg_rd_addr = a;
    it = '{cyc + 1, 1'b1, v, tag};
    sbq.push_back(it);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    cfg_rd_addr = 16'h2000; hw_req = '0; sw_req = '0; ch_ack = '0; ch_en = 4'hF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    expect_rd(16'h2000, 32'h0, "R1"); expect_req(4'b0000, "R1"); tick();

    // R2: program entries, read back the low ENT_W bits
    wr(16'h2000, 32'd1); tick();                                   // id1 -> ch0
    wr(16'h2008, 32'hFFFF_FFF3); expect_rd(16'h2000, 32'd1, "R2"); tick(); // id3 -> ch2
    wr(16'h201C, 32'd2); expect_rd(16'h2008, 32'd3, "R2"); tick();  // id8 -> ch1
    // R3: misaligned, beyond window, below window writes ignored
    wr(16'h2001, 32'd4); expect_rd(16'h201C, 32'd2, "R2"); tick();
    wr(16'h2020, 32'd1); expect_rd(16'h2000, 32'd1, "R3"); tick();
    wr(16'h1FFC, 32'd5); expect_rd(16'h2020, 32'd0, "R3"); tick();
    expect_rd(16'h2004, 32'd0, "R3"); tick();

    // R4 / R8: route, hold, acknowledge
    hw_req = 8'h01; expect_req(4'b0001, "R4"); tick();
    expect_req(4'b0001, "R8"); tick();
    ch_ack = 4'b0001; expect_req(4'b0000, "R8"); tick();
    hw_req = 8'h04; expect_req(4'b0100, "R4"); tick();
    hw_req = 8'h04; ch_ack = 4'b0100; expect_req(4'b0100, "R8"); tick();
    ch_ack = 4'b0100; expect_req(4'b0000, "R8"); tick();

    // R5: unrouted and out-of-range entries
    hw_req = 8'h02; expect_req(4'b0000, "R5"); tick();
    wr(16'h2004, 32'd5); tick();
    hw_req = 8'h02; expect_req(4'b0000, "R5"); expect_rd(16'h2004, 32'd5, "R2"); tick();

    // R6: two requesters share channel 1
    wr(16'h200C, 32'd2); tick();
    hw_req = 8'h88; expect_req(4'b0010, "R6"); tick();
    ch_ack = 4'b0010; expect_req(4'b0000, "R6"); tick();
    hw_req = 8'h80; expect_req(4'b0010, "R6"); tick();
    ch_ack = 4'b0010; expect_req(4'b0000, "R6"); tick();

    // R7: software requests, alone and merged with hardware
    sw_req = 4'b1000; expect_req(4'b1000, "R7"); tick();
    sw_req = 4'b0001; hw_req = 8'h01; ch_ack = 4'b1000; expect_req(4'b0001, "R7"); tick();
    ch_ack = 4'b0001; expect_req(4'b0000, "R7"); tick();

    // R9: disabled channels drop and clear
    ch_en = 4'b0111; hw_req = 8'h01; sw_req = 4'b1000; expect_req(4'b0001, "R9"); tick();
    ch_en = 4'b0110; expect_req(4'b0000, "R9"); tick();
    ch_en = 4'b1111; expect_req(4'b0000, "R9"); tick();

    // R5: disconnect requester 1
    wr(16'h2000, 32'd0); tick();
    hw_req = 8'h01; expect_req(4'b0000, "R5"); expect_rd(16'h2000, 32'd0, "R2"); tick();

    // R1: reset with a request pending clears table and flags
    hw_req = 8'h04; expect_req(4'b0100, "R4"); tick();
    rst_n = 1'b0; tick(); tick();
    rst_n = 1'b1;
    repeat (4) tick();
    expect_rd(16'h2008, 32'd0, "R1"); expect_req(4'b0000, "R1"); tick();

    tick(); tick();
    done = 1;
    summary();
    $finish;
  end

endmodule